// File: doc/BRIEF.md
# Cipher Unit Error Monitor

This block is the control-plane watchdog of a block-cipher accelerator. It sees every register access the host makes into the unit's address window, the push and pop strobes and fill flags of the two shared FIFOs, and the engine's busy and done signals. Each protocol violation it detects sets its own sticky bit in a 64-bit status word. A matching 64-bit mask word selects which of those bits drive the error interrupt. In the mask, a 0 enables a bit and a 1 silences it.

The monitor also owns the small message-control path. It holds the mode, key-length and final-block bit-count registers. A write to the end-of-message offset launches final-block processing, and the monitor passes the bit count to the engine. The engine's done pulse goes out as the done interrupt unless the message carries an illegal bit count. The cipher datapath, the FIFO storage and the bus fabric lie outside the block. It sees them only through their strobes and flags.

All pins are plain control and status signals. No interface carries a data stream, so none has valid/ready flow control. Register accesses are single-cycle strobes and reads return data in the same cycle.

Top module: `cipher_err_monitor`

## Requirements
- R1: A write to the mode, key-length, bit-count, IV (offsets 8–9) or key (offsets 10–13) register while `eng_busy` is 1 sets status bit 53.
- R2: A write to the key-length register (offset 1) of any value other than 16, 24 or 32 sets status bit 54.
- R3: A write to the bit-count register (offset 2) of a value above 128 sets status bit 55. Every later `eng_done` is then kept off `done_irq` until a bit count of 128 or less is written.
- R4: A write to the mode register (offset 0) with any bit at position 3 or higher set sets status bit 56.
- R5: A read or write at an offset with no register behind it sets status bit 57. The mapped offsets are 0–5 and 8–13, and the window is 5 bits wide.
- R6: A write to the bit-count register while `ofifo_empty` is 0 sets status bit 58.
- R7: A `done_irq` pulse while `ififo_empty` is 0 sets status bit 59.
- R8: `ififo_push` while `ififo_full` sets status bit 61. `ofifo_pop` while `ofifo_empty` sets status bit 62.
- R9: Status bits are sticky and are cleared only by writing 1 at their positions to offset 3. If a new error and its clear fall in the same cycle, the bit stays set.
- R10: `err_irq` is 1 exactly when some status bit is set and its mask bit (offset 4) is 0. Only bits 53–59 and 61–62 are held in the status and mask words, and all other bits read as 0.
- R11: A write to offset 5 pulses `final_start` for one cycle on the next clock, with `final_bits` holding the current bit count. A read of offset 5 returns 0.
- R12: After reset the status and mask words are 0, and `err_irq`, `done_irq` and `final_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word offset inside the unit window |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid in the cycle of `reg_rd_en` |
| eng_busy | input | 1 | Engine is processing a message |
| eng_done | input | 1 | Engine finished the final block |
| ififo_push | input | 1 | Input FIFO push strobe |
| ififo_full | input | 1 | Input FIFO full flag |
| ififo_empty | input | 1 | Input FIFO empty flag |
| ofifo_pop | input | 1 | Output FIFO pop strobe |
| ofifo_empty | input | 1 | Output FIFO empty flag |
| final_start | output | 1 | One-cycle start of final-block processing |
| final_bits | output | BITS_W | Bits of the final block to process |
| done_irq | output | 1 | Done interrupt, gated by the bit-count check |
| err_irq | output | 1 | Error interrupt |

## Verification
The bench builds the block with its defaults: a 5-bit window, two IV words, four key words, a 128-bit block and three legal mode bits. With these values the bench can reach the exact boundary between bit counts of 128 and 129. It can also reach the holes in the map, both the gap at offsets 6–7 and the space above the key words. A table of single accesses, each run with or without a busy engine or a non-empty output FIFO, covers the register-side errors one at a time and in pairs. Directed sequences then cover the FIFO strobes, mask polarity, a clear that lands in the same cycle as a new error, and a full message end with and without an illegal bit count.

// File: rtl/cem_pkg.sv
package cem_pkg;
  localparam int DW = 64;

  // status and mask bit positions
  localparam int B_CTX  = 53;
  localparam int B_KLEN = 54;
  localparam int B_CNT  = 55;
  localparam int B_MODE = 56;
  localparam int B_ADDR = 57;
  localparam int B_OFR  = 58;
  localparam int B_IFR  = 59;
  localparam int B_OVF  = 61;
  localparam int B_UNF  = 62;

  localparam logic [DW-1:0] ERR_BITS =
      (64'd1 << B_CTX) | (64'd1 << B_KLEN) | (64'd1 << B_CNT) |
      (64'd1 << B_MODE) | (64'd1 << B_ADDR) | (64'd1 << B_OFR) |
      (64'd1 << B_IFR) | (64'd1 << B_OVF) | (64'd1 << B_UNF);

  // word offsets of the fixed registers
  localparam int OFS_MODE = 0;
  localparam int OFS_KLEN = 1;
  localparam int OFS_CNT  = 2;
  localparam int OFS_STAT = 3;
  localparam int OFS_MASK = 4;
  localparam int OFS_EOM  = 5;
  localparam int OFS_IV   = 8;

  typedef struct packed {
    logic mode;
    logic klen;
    logic cnt;
    logic stat;
    logic mask;
    logic eom;
    logic iv;
    logic key;
    logic hole;
  } reg_hit_t;

  typedef struct packed {
    logic ctx;
    logic klen;
    logic cnt;
    logic mode;
    logic addr;
    logic ofr;
    logic ifr;
    logic ovf;
    logic unf;
  } err_evt_t;

  function automatic logic [DW-1:0] evt_word(err_evt_t e);
    logic [DW-1:0] w;
    w = '0;
    w[B_CTX]  = e.ctx;
    w[B_KLEN] = e.klen;
    w[B_CNT]  = e.cnt;
    w[B_MODE] = e.mode;
    w[B_ADDR] = e.addr;
    w[B_OFR]  = e.ofr;
    w[B_IFR]  = e.ifr;
    w[B_OVF]  = e.ovf;
    w[B_UNF]  = e.unf;
    return w;
  endfunction
endpackage

// File: rtl/cem_decode.sv
module cem_decode
  import cem_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int IV_WORDS  = 2,
  parameter int KEY_WORDS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_hit_t          hit
);
  localparam int KEY_BASE = OFS_IV + IV_WORDS;

  logic [IV_WORDS-1:0]  iv_vec;
  logic [KEY_WORDS-1:0] key_vec;

  for (genvar i = 0; i < IV_WORDS; i++) begin : g_iv
    assign iv_vec[i] = (addr == ADDR_W'(OFS_IV + i));
  end

  for (genvar k = 0; k < KEY_WORDS; k++) begin : g_key
    assign key_vec[k] = (addr == ADDR_W'(KEY_BASE + k));
  end

  always_comb begin
    hit      = '0;
    hit.mode = (addr == ADDR_W'(OFS_MODE));
    hit.klen = (addr == ADDR_W'(OFS_KLEN));
    hit.cnt  = (addr == ADDR_W'(OFS_CNT));
    hit.stat = (addr == ADDR_W'(OFS_STAT));
    hit.mask = (addr == ADDR_W'(OFS_MASK));
    hit.eom  = (addr == ADDR_W'(OFS_EOM));
    hit.iv   = |iv_vec;
    hit.key  = |key_vec;
    hit.hole = ~(hit.mode | hit.klen | hit.cnt | hit.stat | hit.mask |
                 hit.eom | hit.iv | hit.key);
  end
endmodule

// File: rtl/cem_detect.sv
module cem_detect
  import cem_pkg::*;
#(
  parameter int BLOCK_BITS = 128,
  parameter int MODE_BITS  = 3
) (
  input  reg_hit_t        hit,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [DW-1:0]   wdata,
  input  logic            eng_busy,
  input  logic            done_evt,
  input  logic            ififo_push,
  input  logic            ififo_full,
  input  logic            ififo_empty,
  input  logic            ofifo_pop,
  input  logic            ofifo_empty,
  output err_evt_t        evt
);
  localparam logic [DW-1:0] MODE_LEGAL = (DW'(1) << MODE_BITS) - DW'(1);

  logic ctx_target;
  logic klen_ok;

  always_comb begin
    ctx_target = hit.mode | hit.klen | hit.cnt | hit.iv | hit.key;
    klen_ok    = (wdata == DW'(16)) | (wdata == DW'(24)) | (wdata == DW'(32));

    evt      = '0;
    evt.ctx  = wr_en & eng_busy & ctx_target;
    evt.klen = wr_en & hit.klen & ~klen_ok;
    evt.cnt  = wr_en & hit.cnt & (wdata > DW'(BLOCK_BITS));
    evt.mode = wr_en & hit.mode & (|(wdata & ~MODE_LEGAL));
    evt.addr = (wr_en | rd_en) & hit.hole;
    evt.ofr  = wr_en & hit.cnt & ~ofifo_empty;
    evt.ifr  = done_evt & ~ififo_empty;
    evt.ovf  = ififo_push & ififo_full;
    evt.unf  = ofifo_pop & ofifo_empty;
  end
endmodule

// File: rtl/cem_status.sv
module cem_status
  import cem_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  err_evt_t      evt,
  input  logic          stat_wr,
  input  logic          mask_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] mask_q,
  output logic          err_irq
);
  logic [DW-1:0] set_w;
  logic [DW-1:0] clr_w;
  logic [DW-1:0] status_d;

  always_comb begin
    set_w    = evt_word(evt);
    clr_w    = stat_wr ? wdata : '0;
    status_d = ((status_q & ~clr_w) | set_w) & ERR_BITS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= status_d;
      if (mask_wr) mask_q <= wdata & ERR_BITS;
    end
  end

  assign err_irq = |(status_q & ~mask_q);
endmodule

// File: rtl/cem_msg.sv
module cem_msg #(
  parameter int BITS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_wr,
  input  logic              cnt_bad,
  input  logic [BITS_W-1:0] cnt_val,
  input  logic              eom_wr,
  input  logic              eng_done,
  output logic [BITS_W-1:0] cnt_q,
  output logic              final_start,
  output logic [BITS_W-1:0] final_bits,
  output logic              done_irq
);
  logic msg_bad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      msg_bad_q   <= 1'b0;
      final_start <= 1'b0;
      final_bits  <= '0;
    end else begin
      final_start <= eom_wr;
      if (eom_wr) final_bits <= cnt_q;
      if (cnt_wr) begin
        cnt_q     <= cnt_val;
        msg_bad_q <= cnt_bad;
      end
    end
  end

  assign done_irq = eng_done & ~msg_bad_q;
endmodule

// File: rtl/cipher_err_monitor.sv
module cipher_err_monitor
  import cem_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int IV_WORDS   = 2,
  parameter int KEY_WORDS  = 4,
  parameter int BLOCK_BITS = 128,
  parameter int MODE_BITS  = 3,
  localparam int BITS_W    = $clog2(BLOCK_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic              ififo_push,
  input  logic              ififo_full,
  input  logic              ififo_empty,
  input  logic              ofifo_pop,
  input  logic              ofifo_empty,
  output logic              final_start,
  output logic [BITS_W-1:0] final_bits,
  output logic              done_irq,
  output logic              err_irq
);
  localparam int KLEN_W = 6;

  reg_hit_t          hit;
  err_evt_t          evt;
  logic [DW-1:0]     status_q;
  logic [DW-1:0]     mask_q;
  logic [BITS_W-1:0] cnt_q;
  logic [MODE_BITS-1:0] mode_q;
  logic [KLEN_W-1:0] klen_q;

  cem_decode #(
    .ADDR_W(ADDR_W), .IV_WORDS(IV_WORDS), .KEY_WORDS(KEY_WORDS)
  ) u_decode (
    .addr(reg_addr),
    .hit (hit)
  );

  cem_detect #(
    .BLOCK_BITS(BLOCK_BITS), .MODE_BITS(MODE_BITS)
  ) u_detect (
    .hit        (hit),
    .wr_en      (reg_wr_en),
    .rd_en      (reg_rd_en),
    .wdata      (reg_wdata),
    .eng_busy   (eng_busy),
    .done_evt   (done_irq),
    .ififo_push (ififo_push),
    .ififo_full (ififo_full),
    .ififo_empty(ififo_empty),
    .ofifo_pop  (ofifo_pop),
    .ofifo_empty(ofifo_empty),
    .evt        (evt)
  );

  cem_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .stat_wr (reg_wr_en & hit.stat),
    .mask_wr (reg_wr_en & hit.mask),
    .wdata   (reg_wdata),
    .status_q(status_q),
    .mask_q  (mask_q),
    .err_irq (err_irq)
  );

  cem_msg #(.BITS_W(BITS_W)) u_msg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_wr     (reg_wr_en & hit.cnt),
    .cnt_bad    (evt.cnt),
    .cnt_val    (reg_wdata[BITS_W-1:0]),
    .eom_wr     (reg_wr_en & hit.eom),
    .eng_done   (eng_done),
    .cnt_q      (cnt_q),
    .final_start(final_start),
    .final_bits (final_bits),
    .done_irq   (done_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      klen_q <= '0;
    end else if (reg_wr_en) begin
      if (hit.mode) mode_q <= reg_wdata[MODE_BITS-1:0];
      if (hit.klen) klen_q <= reg_wdata[KLEN_W-1:0];
    end
  end

  // key, IV and end-of-message words are write-only and read as zero
  always_comb begin
    reg_rdata = '0;
    if (reg_rd_en) begin
      unique case (1'b1)
        hit.mode: reg_rdata = DW'(mode_q);
        hit.klen: reg_rdata = DW'(klen_q);
        hit.cnt:  reg_rdata = DW'(cnt_q);
        hit.stat: reg_rdata = status_q;
        hit.mask: reg_rdata = mask_q;
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cem_checker.sv
module cem_checker
  import cem_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic              reg_rd_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [63:0]       reg_wdata,
  input logic [63:0]       reg_rdata,
  input logic              eng_busy,
  input logic              eng_done,
  input logic              ififo_push,
  input logic              ififo_full,
  input logic              ofifo_pop,
  input logic              ofifo_empty,
  input logic              final_start,
  input logic              done_irq,
  input logic [63:0]       status_q
);
  logic klen_wr_bad;
  assign klen_wr_bad = reg_wr_en && reg_addr == ADDR_W'(OFS_KLEN) &&
                       reg_wdata != 64'd16 && reg_wdata != 64'd24 && reg_wdata != 64'd32;

  assert_ctx_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && eng_busy && reg_addr == ADDR_W'(OFS_MODE)) |=> status_q[B_CTX]);

  assert_klen_bad_R2: assert property (@(posedge clk) disable iff (!rst_n)
    klen_wr_bad |=> status_q[B_KLEN]);

  assert_done_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> eng_done);

  assert_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ififo_push && ififo_full) |=> status_q[B_OVF]);

  assert_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ofifo_pop && ofifo_empty) |=> status_q[B_UNF]);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[B_OVF] && !(reg_wr_en && reg_addr == ADDR_W'(OFS_STAT) && reg_wdata[B_OVF]))
      |=> status_q[B_OVF]);

  assert_mask_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == ADDR_W'(OFS_MASK)) |-> ((reg_rdata & ~ERR_BITS) == 64'd0));

  assert_start_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    final_start |-> $past(reg_wr_en && reg_addr == ADDR_W'(OFS_EOM)));

  assert_eom_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == ADDR_W'(OFS_EOM)) |-> (reg_rdata == 64'd0));
endmodule

bind cipher_err_monitor cem_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr_en  (reg_wr_en),
  .reg_rd_en  (reg_rd_en),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .eng_busy   (eng_busy),
  .eng_done   (eng_done),
  .ififo_push (ififo_push),
  .ififo_full (ififo_full),
  .ofifo_pop  (ofifo_pop),
  .ofifo_empty(ofifo_empty),
  .final_start(final_start),
  .done_irq   (done_irq),
  .status_q   (status_q)
);

// File: tb/cipher_err_monitor_tb.sv
module cipher_err_monitor_tb;
  localparam logic [63:0] E_CTX  = 64'd1 << 53;
  localparam logic [63:0] E_KLEN = 64'd1 << 54;
  localparam logic [63:0] E_CNT  = 64'd1 << 55;
  localparam logic [63:0] E_MODE = 64'd1 << 56;
  localparam logic [63:0] E_ADDR = 64'd1 << 57;
  localparam logic [63:0] E_OFR  = 64'd1 << 58;
  localparam logic [63:0] E_IFR  = 64'd1 << 59;
  localparam logic [63:0] E_OVF  = 64'd1 << 61;
  localparam logic [63:0] E_UNF  = 64'd1 << 62;
  localparam logic [63:0] E_ALL  = E_CTX | E_KLEN | E_CNT | E_MODE | E_ADDR |
                                   E_OFR | E_IFR | E_OVF | E_UNF;
  localparam logic [4:0] A_MODE = 5'd0, A_KLEN = 5'd1, A_CNT = 5'd2,
                         A_STAT = 5'd3, A_MASK = 5'd4, A_EOM = 5'd5;

  typedef struct packed {
    logic        is_rd;
    logic        busy;
    logic        ofifo_busy;
    logic [4:0]  addr;
    logic [63:0] data;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, A_KLEN, 64'd16,    64'd0},           // R2 legal
    '{1'b0, 1'b0, 1'b0, A_KLEN, 64'd24,    64'd0},           // R2 legal
    '{1'b0, 1'b0, 1'b0, A_KLEN, 64'd32,    64'd0},           // R2 legal
    '{1'b0, 1'b0, 1'b0, A_KLEN, 64'd20,    E_KLEN},          // R2
    '{1'b0, 1'b1, 1'b0, A_KLEN, 64'd16,    E_CTX},           // R1
    '{1'b0, 1'b1, 1'b0, 5'd10,  64'h55,    E_CTX},           // R1 key
    '{1'b0, 1'b1, 1'b0, 5'd9,   64'h66,    E_CTX},           // R1 IV
    '{1'b0, 1'b0, 1'b0, A_MODE, 64'd5,     64'd0},           // R4 legal
    '{1'b0, 1'b0, 1'b0, A_MODE, 64'h100,   E_MODE},          // R4
    '{1'b0, 1'b0, 1'b0, A_CNT,  64'd128,   64'd0},           // R3 boundary
    '{1'b0, 1'b0, 1'b0, A_CNT,  64'd129,   E_CNT},           // R3
    '{1'b0, 1'b0, 1'b1, A_CNT,  64'd64,    E_OFR},           // R6
    '{1'b0, 1'b0, 1'b0, 5'd6,   64'd1,     E_ADDR},          // R5 gap
    '{1'b1, 1'b0, 1'b0, 5'd20,  64'd0,     E_ADDR},          // R5 read
    '{1'b0, 1'b1, 1'b0, A_MODE, 64'h100,   E_CTX | E_MODE},  // R1 R4
    '{1'b0, 1'b1, 1'b0, A_KLEN, 64'd0,     E_CTX | E_KLEN},  // R1 R2
    '{1'b0, 1'b1, 1'b0, A_MASK, 64'd0,     64'd0}            // R1 not ctx
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        eng_busy = 1'b0, eng_done = 1'b0;
  logic        ififo_push = 1'b0, ififo_full = 1'b0, ififo_empty = 1'b1;
  logic        ofifo_pop = 1'b0, ofifo_empty = 1'b1;
  logic        final_start, done_irq, err_irq;
  logic [7:0]  final_bits;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  cipher_err_monitor u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_busy(eng_busy), .eng_done(eng_done),
    .ififo_push(ififo_push), .ififo_full(ififo_full), .ififo_empty(ififo_empty),
    .ofifo_pop(ofifo_pop), .ofifo_empty(ofifo_empty),
    .final_start(final_start), .final_bits(final_bits),
    .done_irq(done_irq), .err_irq(err_irq)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [63:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    rd(A_STAT, r); check("R12 status", r, 64'd0);
    rd(A_MASK, r); check("R12 mask", r, 64'd0);
    check("R12 irq/done/start", {61'd0, err_irq, done_irq, final_start}, 64'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      eng_busy = VECS[i].busy;
      ofifo_empty = ~VECS[i].ofifo_busy;
      if (VECS[i].is_rd) rd(VECS[i].addr, r);
      else wr(VECS[i].addr, VECS[i].data);
      eng_busy = 1'b0; ofifo_empty = 1'b1;
      rd(A_STAT, r);
      check($sformatf("vector %0d R1..R6 status", i), r, VECS[i].exp);
      wr(A_STAT, '1);
    end

    // R8 overflow, R10 irq
    @(negedge clk); ififo_push = 1'b1; ififo_full = 1'b1;
    @(negedge clk); ififo_push = 1'b0; ififo_full = 1'b0;
    check("R10 irq on unmasked", {63'd0, err_irq}, 64'd1);
    rd(A_STAT, r); check("R8 overflow", r, E_OVF);
    // R9 sticky, clear of another bit leaves it
    repeat (3) @(negedge clk);
    wr(A_STAT, E_CTX);
    rd(A_STAT, r); check("R9 sticky", r, E_OVF);
    // R10 mask polarity and reserved bits
    wr(A_MASK, '1);
    rd(A_MASK, r); check("R10 mask readback", r, E_ALL);
    check("R10 masked irq", {63'd0, err_irq}, 64'd0);
    wr(A_MASK, 64'd0);
    check("R10 unmasked irq", {63'd0, err_irq}, 64'd1);
    // R9 set wins over clear
    @(negedge clk);
    ififo_push = 1'b1; ififo_full = 1'b1;
    reg_wr_en = 1'b1; reg_addr = A_STAT; reg_wdata = E_OVF;
    @(negedge clk);
    ififo_push = 1'b0; ififo_full = 1'b0; reg_wr_en = 1'b0;
    rd(A_STAT, r); check("R9 set beats clear", r, E_OVF);
    wr(A_STAT, '1);
    check("R9 cleared irq", {63'd0, err_irq}, 64'd0);
    // push without full
    @(negedge clk); ififo_push = 1'b1;
    @(negedge clk); ififo_push = 1'b0;
    rd(A_STAT, r); check("R8 push not full", r, 64'd0);

    // R8 underflow
    @(negedge clk); ofifo_pop = 1'b1; ofifo_empty = 1'b0;
    @(negedge clk); ofifo_empty = 1'b1;
    @(negedge clk); ofifo_pop = 1'b0;
    rd(A_STAT, r); check("R8 underflow", r, E_UNF);
    wr(A_STAT, '1);

    // R11 end of message
    wr(A_CNT, 64'd100);
    wr(A_EOM, 64'd0);
    check("R11 start pulse", {56'd0, final_start, final_bits[6:0]}, {56'd0, 1'b1, 7'd100});
    @(negedge clk);
    check("R11 start one cycle", {63'd0, final_start}, 64'd0);
    rd(A_EOM, r); check("R11 eom reads zero", r, 64'd0);
    rd(A_STAT, r); check("R11 no error", r, 64'd0);

    // R3 / R7 done gating and input residue
    @(negedge clk); eng_done = 1'b1;
    #1 check("R3 done passes", {63'd0, done_irq}, 64'd1);
    @(negedge clk); eng_done = 1'b0;
    rd(A_STAT, r); check("R7 empty input", r, 64'd0);
    @(negedge clk); eng_done = 1'b1; ififo_empty = 1'b0;
    @(negedge clk); eng_done = 1'b0;
    rd(A_STAT, r); check("R7 residue", r, E_IFR);
    wr(A_STAT, '1);
    wr(A_CNT, 64'd200);
    wr(A_STAT, '1);
    @(negedge clk); eng_done = 1'b1;
    #1 check("R3 done suppressed", {63'd0, done_irq}, 64'd0);
    @(negedge clk); eng_done = 1'b0;
    rd(A_STAT, r); check("R7 no residue without done", r, 64'd0);
    ififo_empty = 1'b1;
    wr(A_CNT, 64'd50);
    @(negedge clk); eng_done = 1'b1;
    #1 check("R3 done restored", {63'd0, done_irq}, 64'd1);
    @(negedge clk); eng_done = 1'b0;

    report();
  end
endmodule